// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Tracker

This block watches a decoded DDR SDRAM command stream, one command per rising clock edge, and keeps a model of four internal banks: whether each is open, how long ago each timing-relevant event happened, and whether an auto-precharge is pending. For every clock cycle it decides whether the command presented in that cycle is legal. One cycle later it reports the verdict as a registered vector with one bit per rule, together with an overall pass flag. It also keeps an error flag that stays set once any rule has been broken.

Timing limits are parameters given in picoseconds. They are turned into cycle counts by rounding up against the clock period, which defaults to 6 ns. The tracker sits beside a memory controller or a command-stream monitor and does not affect the stream. Data path, strobe capture, mode register contents and refresh scheduling are not modelled.

Top module: `ddr_bank_tracker`

## Requirements
- R1: The command is decoded from active-low strobes (ras_n, cas_n, we_n): 011 activate, 101 read, 100 write, 010 precharge, 000 mode register set, 111 no operation. The codes 001 (refresh) and 110 (burst stop) are subject only to the R10 check. While cs_n is high the cycle is a no-operation: no bank changes state and no rule bit other than bit 4 is raised. Timers keep running while cs_n is high.
- R2: The bank number is ba, with ba[0] as the low bit. bank_open[i] is high while bank i is open.
- R3: An activate opens the addressed bank. A precharge with a10 low closes only the addressed bank. A precharge with a10 high closes every bank. The change is visible on bank_open after the clock edge that takes the command.
- R4: Viol bit 0 is raised for a read or write to a closed bank, and for an activate to a bank that is already open.
- R5: Viol bit 1 is raised when a read or write reaches an open bank fewer than 3 cycles after that bank's activate. Viol bit 2 is raised when an activate follows a precharge that closed that bank by fewer than 3 cycles.
- R6: Viol bit 3 is raised when a precharge closes a bank fewer than 7 cycles after its activate. Viol bit 4 is raised, in a cycle of its own, when a bank has been open for 20001 cycles (more than 20000) without being closed.
- R7: Viol bit 5 is raised when two activates to the same bank are fewer than 10 cycles apart. Viol bit 6 is raised when two activates to different banks are fewer than 2 cycles apart.
- R8: Viol bit 7 is raised when a precharge closes a bank fewer than 4+BL/2 cycles after a write to it. Viol bit 8 is raised when the gap after a read to it is fewer than BL/2 cycles. BL is the burst length (2, 4 or 8) carried with the earlier command.
- R9: Viol bit 9 is raised when a read comes fewer than 2+BL/2 cycles after a write. Viol bit 10 is raised when a write comes fewer than 3+BL/2 cycles after a read. Both apply across all banks.
- R10: Viol bit 11 is raised for any command (cs_n low, not no-operation) issued fewer than 3 cycles after a mode register set, which leaves 2 idle cycles between them.
- R11: A read or write to an open bank with a10 high closes that bank. Viol bit 12 is raised if the bank is activated again too soon. After a write the gap must be at least 1+BL/2+6 cycles, where 6 is the write-recovery-plus-precharge count. After a read the gap must be at least BL/2+3 cycles.
- R12: The viol vector and cmd_ok (high when no bit is set) are registered and show the verdict one cycle after the command. sticky_err is set by any violation and stays set until reset. After reset all banks are closed, viol is zero, cmd_ok is high and sticky_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Precharge-all / auto-precharge select |
| bl_len | input | 4 | Burst length of this command (2, 4 or 8) |
| cmd_ok | output | 1 | Previous cycle's command broke no rule |
| viol | output | 13 | Per-rule violation bits for previous cycle |
| sticky_err | output | 1 | Any violation since reset |
| bank_open | output | 4 | Open state of each bank |

## Verification
Every spacing rule is swept over gaps from one cycle up to one past its limit, from a freshly reset state. This pins the exact cycle at which each bit stops firing, which separates an off-by-one in a counter load from a correct bound. The burst-dependent rules are swept for each of the three burst lengths, so a wrong halving or a wrong constant offset shows up as a shifted edge. Bank-selection patterns (single-bank and all-bank precharge, activates to different banks, deselected commands) tell the addressed-bank path apart from the global path. A single long idle run after one activate locates the open-too-long flag on its exact cycle.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
  } cmd_e;

  localparam int NV        = 13;
  localparam int V_STATE   = 0;
  localparam int V_RCD     = 1;
  localparam int V_RP      = 2;
  localparam int V_RASMIN  = 3;
  localparam int V_RASMAX  = 4;
  localparam int V_RC      = 5;
  localparam int V_RRD     = 6;
  localparam int V_WR2PRE  = 7;
  localparam int V_RD2PRE  = 8;
  localparam int V_WR2RD   = 9;
  localparam int V_RD2WR   = 10;
  localparam int V_MRD     = 11;
  localparam int V_DAL     = 12;

  // round a picosecond limit up to whole clock cycles
  function automatic int ps2cyc(input int ps, input int tck_ps);
    return (ps + tck_ps - 1) / tck_ps;
  endfunction

  function automatic int gap_wr2pre(input int half);
    return 4 + half;
  endfunction

  function automatic int gap_rd2pre(input int half);
    return half;
  endfunction

  function automatic int gap_wr2rd(input int half);
    return 2 + half;
  endfunction

  function automatic int gap_rd2wr(input int half);
    return 3 + half;
  endfunction

  function automatic int gap_wrap_act(input int half, input int dal);
    return 1 + half + dal;
  endfunction

  function automatic int gap_rdap_act(input int half, input int rp);
    return half + rp;
  endfunction

  // countdown value to load for a minimum gap of g cycles
  function automatic int wait_load(input int g);
    return (g > 1) ? g - 1 : 0;
  endfunction

endpackage

// File: rtl/ddr_trk_decode.sv
module ddr_trk_decode
  import ddr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = C_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        3'b110:  cmd = C_BST;
        default: cmd = C_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_trk_bank.sv
module ddr_trk_bank
  import ddr_trk_pkg::*;
#(
  parameter int RCD    = 3,
  parameter int RP     = 3,
  parameter int RAS    = 7,
  parameter int RASMAX = 20000,
  parameter int RC     = 10,
  parameter int DAL    = 6,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_hit,
  input  logic          rd_hit,
  input  logic          wr_hit,
  input  logic          pre_hit,
  input  logic          ap,
  input  logic [2:0]    bl_half,
  output logic          is_open,
  output logic [NV-1:0] v
);

  localparam int AW = $clog2(RASMAX + 3);
  localparam logic [AW-1:0] AGE_FLAG = AW'(RASMAX + 1);
  localparam logic [AW-1:0] AGE_SAT  = AW'(RASMAX + 2);

  logic          open_q;
  logic [CW-1:0] rcd_w, rp_w, ras_w, rc_w, wp_w, rdp_w, dal_w;
  logic [AW-1:0] age_q;

  // named events for checking
  logic col_hit, col_open, close_by_pre, close_by_ap, ras_expired;
  assign col_hit      = rd_hit | wr_hit;
  assign col_open     = col_hit & open_q;
  assign close_by_pre = pre_hit & open_q;
  assign close_by_ap  = col_open & ap;
  assign ras_expired  = open_q && (age_q == AGE_FLAG);
  assign is_open      = open_q;

  function automatic logic [CW-1:0] tick(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  function automatic logic [CW-1:0] ld(input int g);
    return CW'(wait_load(g));
  endfunction

  always_comb begin
    v = '0;
    v[V_STATE]  = (act_hit && open_q) || (col_hit && !open_q);
    v[V_RCD]    = col_open && (rcd_w != '0);
    v[V_RP]     = act_hit && (rp_w != '0);
    v[V_DAL]    = act_hit && (dal_w != '0);
    v[V_RC]     = act_hit && (rc_w != '0);
    v[V_RASMIN] = close_by_pre && (ras_w != '0);
    v[V_RASMAX] = ras_expired;
    v[V_WR2PRE] = close_by_pre && (wp_w != '0);
    v[V_RD2PRE] = close_by_pre && (rdp_w != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_w  <= '0;
      rp_w   <= '0;
      ras_w  <= '0;
      rc_w   <= '0;
      wp_w   <= '0;
      rdp_w  <= '0;
      dal_w  <= '0;
      age_q  <= '0;
    end else begin
      rcd_w <= tick(rcd_w);
      rp_w  <= tick(rp_w);
      ras_w <= tick(ras_w);
      rc_w  <= tick(rc_w);
      wp_w  <= tick(wp_w);
      rdp_w <= tick(rdp_w);
      dal_w <= tick(dal_w);
      if (act_hit) begin
        open_q <= 1'b1;
        rcd_w  <= ld(RCD);
        ras_w  <= ld(RAS);
        rc_w   <= ld(RC);
        age_q  <= AW'(1);
      end else if (open_q && age_q != AGE_SAT) begin
        age_q  <= age_q + 1'b1;
      end
      if (col_open) begin
        if (wr_hit) wp_w  <= ld(gap_wr2pre(int'(bl_half)));
        if (rd_hit) rdp_w <= ld(gap_rd2pre(int'(bl_half)));
        if (ap) begin
          open_q <= 1'b0;
          dal_w  <= wr_hit ? ld(gap_wrap_act(int'(bl_half), DAL))
                           : ld(gap_rdap_act(int'(bl_half), RP));
        end
      end
      if (close_by_pre) begin
        open_q <= 1'b0;
        rp_w   <= ld(RP);
      end
    end
  end

  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |=> open_q);
  // R3
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_hit |=> !open_q);
  // R11
  ap_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_by_ap |=> !open_q);
  // R5
  rcd_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hit ##1 col_hit) |-> v[V_RCD]);

endmodule

// File: rtl/ddr_trk_xbank.sv
module ddr_trk_xbank
  import ddr_trk_pkg::*;
#(
  parameter int RRD      = 2,
  parameter int MRD_IDLE = 2,
  parameter int CW       = 6,
  parameter int BA_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act,
  input  logic            rd,
  input  logic            wr,
  input  logic            mrs,
  input  logic            any_cmd,
  input  logic [BA_W-1:0] ba,
  input  logic [2:0]      bl_half,
  output logic [NV-1:0]   v
);

  logic [CW-1:0]   rrd_w, w2r_w, r2w_w, mrd_w;
  logic [BA_W-1:0] last_ba;
  logic            other_bank;

  assign other_bank = (ba != last_ba);

  function automatic logic [CW-1:0] tick(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  function automatic logic [CW-1:0] ld(input int g);
    return CW'(wait_load(g));
  endfunction

  always_comb begin
    v = '0;
    v[V_RRD]   = act && other_bank && (rrd_w != '0);
    v[V_WR2RD] = rd && (w2r_w != '0);
    v[V_RD2WR] = wr && (r2w_w != '0);
    v[V_MRD]   = any_cmd && (mrd_w != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_w   <= '0;
      w2r_w   <= '0;
      r2w_w   <= '0;
      mrd_w   <= '0;
      last_ba <= '0;
    end else begin
      rrd_w <= tick(rrd_w);
      w2r_w <= tick(w2r_w);
      r2w_w <= tick(r2w_w);
      mrd_w <= tick(mrd_w);
      if (act) begin
        rrd_w   <= ld(RRD);
        last_ba <= ba;
      end
      if (wr)  w2r_w <= ld(gap_wr2rd(int'(bl_half)));
      if (rd)  r2w_w <= ld(gap_rd2wr(int'(bl_half)));
      if (mrs) mrd_w <= ld(MRD_IDLE + 1);
    end
  end

  // R10
  mrd_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs ##1 any_cmd) |-> v[V_MRD]);
  // R9
  wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr ##1 rd) |-> v[V_WR2RD]);

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_trk_pkg::*;
#(
  parameter int NBANK       = 4,
  parameter int TCK_PS      = 6000,
  parameter int TRCD_PS     = 18000,
  parameter int TRP_PS      = 18000,
  parameter int TRAS_PS     = 42000,
  parameter int TRAS_MAX_PS = 120000000,
  parameter int TRC_PS      = 60000,
  parameter int TRRD_PS     = 12000,
  parameter int TWR_PS      = 15000,
  parameter int MRD_IDLE    = 2,
  localparam int BA_W       = $clog2(NBANK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic [3:0]      bl_len,
  output logic            cmd_ok,
  output logic [NV-1:0]   viol,
  output logic            sticky_err,
  output logic [NBANK-1:0] bank_open
);

  localparam int RCD_C    = ps2cyc(TRCD_PS, TCK_PS);
  localparam int RP_C     = ps2cyc(TRP_PS, TCK_PS);
  localparam int RAS_C    = ps2cyc(TRAS_PS, TCK_PS);
  localparam int RASMAX_C = ps2cyc(TRAS_MAX_PS, TCK_PS);
  localparam int RC_C     = ps2cyc(TRC_PS, TCK_PS);
  localparam int RRD_C    = ps2cyc(TRRD_PS, TCK_PS);
  localparam int DAL_C    = ps2cyc(TWR_PS, TCK_PS) + RP_C;
  localparam int CW       = $clog2(RC_C + DAL_C + RAS_C + MRD_IDLE + 16);

  cmd_e            cmd;
  logic            is_act, is_rd, is_wr, is_pre, is_mrs, any_cmd;
  logic [2:0]      bl_half;
  logic [NBANK-1:0] sel;
  logic [NV-1:0]   xv;
  logic [NV-1:0]   bv [NBANK];
  logic [NV-1:0]   viol_now;

  ddr_trk_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign is_act  = (cmd == C_ACT);
  assign is_rd   = (cmd == C_RD);
  assign is_wr   = (cmd == C_WR);
  assign is_pre  = (cmd == C_PRE);
  assign is_mrs  = (cmd == C_MRS);
  assign any_cmd = (cmd != C_NOP);
  assign bl_half = bl_len[3:1];

  always_comb begin
    sel = '0;
    sel[ba] = 1'b1;
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    ddr_trk_bank #(
      .RCD(RCD_C), .RP(RP_C), .RAS(RAS_C), .RASMAX(RASMAX_C),
      .RC(RC_C), .DAL(DAL_C), .CW(CW)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_hit (is_act & sel[i]),
      .rd_hit  (is_rd & sel[i]),
      .wr_hit  (is_wr & sel[i]),
      .pre_hit (is_pre & (a10 | sel[i])),
      .ap      (a10),
      .bl_half (bl_half),
      .is_open (bank_open[i]),
      .v       (bv[i])
    );
  end

  ddr_trk_xbank #(
    .RRD(RRD_C), .MRD_IDLE(MRD_IDLE), .CW(CW), .BA_W(BA_W)
  ) u_xbank (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (is_act),
    .rd      (is_rd),
    .wr      (is_wr),
    .mrs     (is_mrs),
    .any_cmd (any_cmd),
    .ba      (ba),
    .bl_half (bl_half),
    .v       (xv)
  );

  always_comb begin
    viol_now = xv;
    for (int i = 0; i < NBANK; i++) viol_now = viol_now | bv[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol       <= '0;
      cmd_ok     <= 1'b1;
      sticky_err <= 1'b0;
    end else begin
      viol       <= viol_now;
      cmd_ok     <= ~|viol_now;
      sticky_err <= sticky_err | (|viol_now);
    end
  end

  // R12
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_err |=> sticky_err);
  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ((viol & ~(NV'(1) << V_RASMAX)) == '0));
  // R1
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(bank_open));

endmodule

// File: tb/ddr_bank_tracker_tb_top.sv
module ddr_bank_tracker_tb_top;

  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_PRE = 3'b010, K_MRS = 3'b000, K_NOP = 3'b111;
  localparam int RASMAX = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [3:0] bl_len = 4'd4;
  logic cmd_ok, sticky_err;
  logic [12:0] viol;
  logic [3:0] bank_open;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  ddr_bank_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .bl_len(bl_len), .cmd_ok(cmd_ok),
    .viol(viol), .sticky_err(sticky_err), .bank_open(bank_open)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [1:0] b,
                       input logic a, input logic [3:0] bl);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = c; ba = b; a10 = a; bl_len = bl;
    @(negedge clk);
    {ras_n, cas_n, we_n} = K_NOP;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    cs_n = 1'b0; {ras_n, cas_n, we_n} = K_NOP; a10 = 1'b0;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R12 reset state
    chk("R12 reset open", int'(bank_open), 0);
    chk("R12 reset viol", int'(viol), 0);
    chk("R12 reset ok", int'(cmd_ok), 1);
    chk("R12 reset sticky", int'(sticky_err), 0);

    // R2 R3 bank selection and precharge scope
    issue(K_ACT, 2'd1, 0, 4);
    chk("R2 ba=1 opens bit1", int'(bank_open), 2);
    idle(1);
    issue(K_ACT, 2'd2, 0, 4);
    chk("R3 two open", int'(bank_open), 6);
    idle(10);
    issue(K_PRE, 2'd1, 0, 4);
    chk("R3 single precharge", int'(bank_open), 4);
    chk("R3 legal pre ok", int'(cmd_ok), 1);
    idle(3);
    issue(K_ACT, 2'd0, 0, 4);
    idle(10);
    issue(K_PRE, 2'd3, 1, 4);
    chk("R3 precharge all", int'(bank_open), 0);
    chk("R12 sticky clean", int'(sticky_err), 0);

    // R4 state errors and R12 flags
    do_reset();
    issue(K_RD, 2'd3, 0, 4);
    chk("R4 read closed", int'(viol[0]), 1);
    chk("R12 ok low", int'(cmd_ok), 0);
    idle(1);
    chk("R12 ok back", int'(cmd_ok), 1);
    chk("R12 sticky held", int'(sticky_err), 1);
    issue(K_ACT, 2'd3, 0, 4);
    idle(12);
    issue(K_ACT, 2'd3, 0, 4);
    chk("R4 act open", int'(viol[0]), 1);
    chk("R7 same bank no rrd", int'(viol[6]), 0);

    // R1 deselect: no state change, timers run
    do_reset();
    cs_n = 1'b1; {ras_n, cas_n, we_n} = K_ACT; ba = 2'd0;
    @(negedge clk);
    chk("R1 desel act closed", int'(bank_open), 0);
    chk("R1 desel quiet", int'(viol), 0);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = K_NOP;
    issue(K_ACT, 2'd0, 0, 4);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = K_RD;
    idle(2);
    chk("R1 desel rd quiet", int'(viol), 0);
    cs_n = 1'b0;
    issue(K_RD, 2'd0, 0, 4);
    chk("R1 timer ran", int'(viol[1]), 0);

    // R5 tRCD
    for (int g = 1; g <= 4; g++) begin
      do_reset(); issue(K_ACT, 0, 0, 4); idle(g - 1); issue(K_RD, 0, 0, 4);
      chk("R5 rcd", int'(viol[1]), int'(g < 3));
    end
    // R5 tRP
    for (int g = 1; g <= 4; g++) begin
      do_reset(); issue(K_ACT, 0, 0, 4); idle(10); issue(K_PRE, 0, 0, 4);
      idle(g - 1); issue(K_ACT, 0, 0, 4);
      chk("R5 rp", int'(viol[2]), int'(g < 3));
    end
    // R6 tRAS min
    for (int g = 1; g <= 8; g++) begin
      do_reset(); issue(K_ACT, 1, 0, 4); idle(g - 1); issue(K_PRE, 1, 0, 4);
      chk("R6 ras min", int'(viol[3]), int'(g < 7));
    end
    // R7 tRC (precharge early so tRP is met)
    for (int g = 5; g <= 11; g++) begin
      do_reset(); issue(K_ACT, 2, 0, 4); idle(1); issue(K_PRE, 2, 0, 4);
      idle(g - 3); issue(K_ACT, 2, 0, 4);
      chk("R7 rc", int'(viol[5]), int'(g < 10));
    end
    // R7 tRRD
    for (int g = 1; g <= 3; g++) begin
      do_reset(); issue(K_ACT, 0, 0, 4); idle(g - 1); issue(K_ACT, 3, 0, 4);
      chk("R7 rrd", int'(viol[6]), int'(g < 2));
    end
    // R10 tMRD
    for (int g = 1; g <= 4; g++) begin
      do_reset(); issue(K_MRS, 0, 0, 4); idle(g - 1); issue(K_ACT, 0, 0, 4);
      chk("R10 mrd", int'(viol[11]), int'(g < 3));
    end

    // burst-length dependent rules
    for (int k = 0; k < 3; k++) begin
      automatic logic [3:0] bl = 4'(2 << k);
      automatic int h = 1 << k;
      for (int g = 1; g <= 5 + h; g++) begin
        do_reset(); issue(K_ACT, 0, 0, 4); idle(3); issue(K_WR, 0, 0, bl);
        idle(g - 1); issue(K_PRE, 0, 0, 4);
        chk("R8 wr2pre", int'(viol[7]), int'(g < 4 + h));
      end
      for (int g = 1; g <= h + 1; g++) begin
        do_reset(); issue(K_ACT, 0, 0, 4); idle(3); issue(K_RD, 0, 0, bl);
        idle(g - 1); issue(K_PRE, 0, 0, 4);
        chk("R8 rd2pre", int'(viol[8]), int'(g < h));
      end
      for (int g = 1; g <= 3 + h; g++) begin
        do_reset(); issue(K_ACT, 0, 0, 4); idle(3); issue(K_WR, 0, 0, bl);
        idle(g - 1); issue(K_RD, 0, 0, 4);
        chk("R9 wr2rd", int'(viol[9]), int'(g < 2 + h));
      end
      for (int g = 1; g <= 4 + h; g++) begin
        do_reset(); issue(K_ACT, 0, 0, 4); idle(3); issue(K_RD, 0, 0, bl);
        idle(g - 1); issue(K_WR, 0, 0, 4);
        chk("R9 rd2wr", int'(viol[10]), int'(g < 3 + h));
      end
      for (int g = 1; g <= 8 + h; g++) begin
        do_reset(); issue(K_ACT, 0, 0, 4); idle(3); issue(K_WR, 0, 1, bl);
        if (g == 1) chk("R11 wr ap closes", int'(bank_open[0]), 0);
        idle(g - 1); issue(K_ACT, 0, 0, 4);
        chk("R11 wr ap dal", int'(viol[12]), int'(g < 7 + h));
      end
      for (int g = 1; g <= h + 4; g++) begin
        do_reset(); issue(K_ACT, 0, 0, 4); idle(3); issue(K_RD, 0, 1, bl);
        idle(g - 1); issue(K_ACT, 0, 0, 4);
        chk("R11 rd ap", int'(viol[12]), int'(g < h + 3));
      end
    end

    // R6 tRAS max: first flag at gap RASMAX+1
    do_reset();
    issue(K_ACT, 0, 0, 4);
    begin
      int first = 0;
      for (int k = 1; k <= RASMAX + 10; k++) begin
        idle(1);
        if (viol[4] && first == 0) first = k;
      end
      chk("R6 ras max cycle", first, RASMAX + 1);
    end

    report();
    $finish;
  end

endmodule